// File: doc/BRIEF.md
# Ethernet Receive Reader over an Indirect Parallel Bus

This block pulls received raw-mode frames out of an external Ethernet controller. The controller's memory is not wired directly to the block. Instead, the block reaches it over an 8-bit bus with a 2-bit register select, which gives three registers and a data port:

- a mode register,
- a high byte of a pointer,
- a low byte of a pointer,
- a data port that reads or writes the byte at that pointer.

Once the controller has auto-increment turned on, one pointer load followed by consecutive data-port accesses walks through memory one byte at a time.

The block starts when the host pulses `init_req`. It holds the controller in reset for a short pulse, waits out a settle time and then turns on auto-increment. From then on, a low level on the controller interrupt starts a receive pass, which runs these steps in order:

1. Read the 16-bit pending-size register.
2. Read the 16-bit receive read pointer.
3. Locate the frame in the receive buffer and read its 2-byte length header.
4. Stream the frame body out on a valid/ready byte interface, with start and end markers.
5. Write the advanced read pointer back.
6. Issue the receive command that releases the frame.

Top module: `ipb_rx_reader`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `bus_cs_n`, `bus_rd_n`, `bus_wr_n` and `ctrl_rst_n` are 1, and `bus_data_oe` and `rx_valid` are 0.
- R2: An `init_req` pulse while idle or waiting does the following in order. It drives `ctrl_rst_n` low for exactly RST_PULSE cycles with no bus activity. It then holds the bus quiet for at least SETTLE_CYCLES cycles after `ctrl_rst_n` rises. Its first bus write puts 0x02 into select 0, the mode register, where bit 1 is auto-increment.
- R3: `ctrl_int_n` low has no effect before the first initialisation has finished: `bus_cs_n` stays high.
- R4: Every bus cycle lowers `bus_cs_n` at least one cycle before its strobe falls, keeps it low through the cycle in which the strobe rises, and never lowers `bus_rd_n` and `bus_wr_n` together. Neither strobe is ever low while `bus_cs_n` is high.
- R5: `bus_data_oe` is high only inside write cycles (`bus_cs_n` low, `bus_rd_n` high), covers the whole time `bus_wr_n` is low, and `bus_data_o` is constant while `bus_wr_n` is low.
- R6: With the interrupt low, the block reads the 16-bit size at controller address 0x0426/0x0427, high byte first, using select 1 (pointer high), select 2 (pointer low) and select 3 (data). If the size is zero, it writes nothing to the data port and issues no command.
- R7: The frame begins at 0x6000 + (read pointer AND 0x1FFF), where the read pointer is the big-endian value at 0x0428/0x0429. The frame's first two bytes are a big-endian length that includes those two bytes.
- R8: The block presents the length minus 2 body bytes on `rx_data` in memory order. `rx_sof` marks the first byte and `rx_eof` marks the last; a one-byte frame carries both. Each byte, together with its markers, is held until `rx_ready` is high. The markers are never high without `rx_valid`.
- R9: A frame whose length is 2 or less produces no output byte, but its pointer write-back and command still happen.
- R10: After a frame, the block writes old pointer + length to 0x0428 (high byte), then to 0x0429 (low byte), then writes 0x40 to 0x0401. These are its last three data-port writes of that pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_req | input | 1 | One-cycle request to reset and initialise the controller |
| ctrl_rst_n | output | 1 | Controller hardware reset, active low |
| ctrl_int_n | input | 1 | Controller interrupt, active low, asynchronous |
| bus_addr | output | 2 | Register select: 0 mode, 1 pointer high, 2 pointer low, 3 data |
| bus_data_o | output | 8 | Write data toward the controller |
| bus_data_oe | output | 1 | Drive enable for the data bus |
| bus_data_i | input | 8 | Read data from the controller |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| rx_data | output | 8 | Frame body byte |
| rx_valid | output | 1 | Byte is presented |
| rx_ready | input | 1 | Downstream accepts the byte |
| rx_sof | output | 1 | First byte of a frame |
| rx_eof | output | 1 | Last byte of a frame |

## Verification
The bound checker tests the bus-cycle shape on every cycle: select setup and hold around each strobe, no overlap of the two strobes, drive enable confined to write cycles, and stable write data. It also checks that the bus stays quiet during the controller reset and that the output byte and its markers are held under back-pressure.

Some behaviour depends on controller contents and on the order of a whole pass, and only the bench scenarios can show it. This covers the computed frame address with pointer masking, header stripping, empty and single-byte frames, the zero-size early exit, the written-back pointer value and the order of the final three writes. The bench therefore models the controller's register file and memory, including auto-increment, and compares every accepted byte against a queue of expected bytes.

// File: rtl/ipb_rx_pkg.sv
package ipb_rx_pkg;

  typedef enum logic [1:0] {
    BA_MODE    = 2'd0,
    BA_ADDR_HI = 2'd1,
    BA_ADDR_LO = 2'd2,
    BA_DATA    = 2'd3
  } bus_sel_e;

  localparam logic [7:0]  MODE_AUTOINC = 8'h02;
  localparam logic [15:0] REG_RX_SIZE  = 16'h0426;
  localparam logic [15:0] REG_RX_PTR   = 16'h0428;
  localparam logic [15:0] REG_SOCK_CMD = 16'h0401;
  localparam logic [7:0]  CMD_RECV     = 8'h40;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_RST, SQ_SETTLE, SQ_MODE, SQ_WAIT, SQ_SIZE,
    SQ_PTR, SQ_HDR, SQ_DATA, SQ_EMIT, SQ_WBP, SQ_CMD
  } seq_state_e;

  typedef struct packed {
    bus_sel_e   sel;
    logic       wr;
    logic [7:0] wdata;
  } bus_op_t;

endpackage

// File: rtl/ipb_bus_cycle.sv
module ipb_bus_cycle
  import ipb_rx_pkg::*;
#(
  parameter int STROBE_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  bus_op_t    op,
  output logic       done,
  output logic [7:0] rdata,
  output logic [1:0] bus_addr,
  output logic [7:0] bus_data_o,
  output logic       bus_data_oe,
  input  logic [7:0] bus_data_i,
  output logic       bus_cs_n,
  output logic       bus_rd_n,
  output logic       bus_wr_n
);

  localparam int CW = $clog2(STROBE_CYCLES + 1);

  typedef enum logic [1:0] {E_IDLE, E_SETUP, E_STRB, E_HOLD} phase_e;

  phase_e        ph;
  logic [CW-1:0] cnt;
  logic          wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph          <= E_IDLE;
      cnt         <= '0;
      wr_q        <= 1'b0;
      done        <= 1'b0;
      rdata       <= '0;
      bus_addr    <= '0;
      bus_data_o  <= '0;
      bus_data_oe <= 1'b0;
      bus_cs_n    <= 1'b1;
      bus_rd_n    <= 1'b1;
      bus_wr_n    <= 1'b1;
    end else begin
      done <= 1'b0;
      case (ph)
        E_IDLE: if (req) begin
          bus_addr    <= op.sel;
          bus_data_o  <= op.wdata;
          bus_data_oe <= op.wr;
          wr_q        <= op.wr;
          bus_cs_n    <= 1'b0;
          ph          <= E_SETUP;
        end
        E_SETUP: begin
          if (wr_q) bus_wr_n <= 1'b0;
          else      bus_rd_n <= 1'b0;
          cnt <= CW'(STROBE_CYCLES - 1);
          ph  <= E_STRB;
        end
        E_STRB: begin
          if (cnt == '0) begin
            bus_rd_n <= 1'b1;
            bus_wr_n <= 1'b1;
            rdata    <= bus_data_i;
            ph       <= E_HOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          bus_cs_n    <= 1'b1;
          bus_data_oe <= 1'b0;
          done        <= 1'b1;
          ph          <= E_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/ipb_rx_seq.sv
module ipb_rx_seq
  import ipb_rx_pkg::*;
#(
  parameter int          RST_PULSE     = 4,
  parameter int          SETTLE_CYCLES = 24000,
  parameter logic [15:0] RX_BASE       = 16'h6000,
  parameter logic [15:0] RX_MASK       = 16'h1FFF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       init_req,
  input  logic       irq,
  output logic       req,
  output bus_op_t    op,
  input  logic       done,
  input  logic [7:0] rdata,
  output logic       ctrl_rst_n,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic       rx_sof,
  output logic       rx_eof
);

  localparam int CNT_MAX = (RST_PULSE > SETTLE_CYCLES) ? RST_PULSE : SETTLE_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  seq_state_e       st;
  logic [1:0]       sub;
  logic             pend;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       word_lo;
  logic [15:0]      rp, flen, remaining;
  logic             first;

  logic [15:0] target, new_rp, frame_addr, rd16;
  logic [1:0]  last_sub;
  logic        is_op;

  assign new_rp     = rp + flen;
  assign frame_addr = RX_BASE + (rp & RX_MASK);
  assign rd16       = {word_lo, rdata};

  always_comb begin
    target   = '0;
    last_sub = 2'd3;
    is_op    = 1'b1;
    case (st)
      SQ_SIZE:          target = REG_RX_SIZE;
      SQ_PTR:           target = REG_RX_PTR;
      SQ_HDR:           target = frame_addr;
      SQ_WBP:           target = REG_RX_PTR;
      SQ_CMD:           begin target = REG_SOCK_CMD; last_sub = 2'd2; end
      SQ_MODE, SQ_DATA: last_sub = 2'd0;
      default:          is_op = 1'b0;
    endcase
    case (sub)
      2'd0:    begin op.sel = BA_ADDR_HI; op.wr = 1'b1; op.wdata = target[15:8]; end
      2'd1:    begin op.sel = BA_ADDR_LO; op.wr = 1'b1; op.wdata = target[7:0]; end
      default: begin
        op.sel   = BA_DATA;
        op.wr    = (st == SQ_WBP) || (st == SQ_CMD);
        op.wdata = (st == SQ_CMD) ? CMD_RECV : ((sub == 2'd2) ? new_rp[15:8] : new_rp[7:0]);
      end
    endcase
    if (st == SQ_MODE) begin
      op.sel = BA_MODE; op.wr = 1'b1; op.wdata = MODE_AUTOINC;
    end else if (st == SQ_DATA) begin
      op.sel = BA_DATA; op.wr = 1'b0; op.wdata = 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= SQ_IDLE;
      sub        <= '0;
      pend       <= 1'b0;
      req        <= 1'b0;
      cnt        <= '0;
      word_lo    <= '0;
      rp         <= '0;
      flen       <= '0;
      remaining  <= '0;
      first      <= 1'b0;
      ctrl_rst_n <= 1'b1;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      rx_sof     <= 1'b0;
      rx_eof     <= 1'b0;
    end else begin
      req <= 1'b0;
      if (is_op && !pend) begin
        req  <= 1'b1;
        pend <= 1'b1;
      end
      case (st)
        SQ_IDLE: if (init_req) begin
          ctrl_rst_n <= 1'b0;
          cnt        <= CNT_W'(RST_PULSE - 1);
          st         <= SQ_RST;
        end
        SQ_RST: begin
          if (cnt == '0) begin
            ctrl_rst_n <= 1'b1;
            cnt        <= CNT_W'(SETTLE_CYCLES - 1);
            st         <= SQ_SETTLE;
          end else cnt <= cnt - 1'b1;
        end
        SQ_SETTLE: begin
          if (cnt == '0) begin
            sub <= '0;
            st  <= SQ_MODE;
          end else cnt <= cnt - 1'b1;
        end
        SQ_WAIT: begin
          if (init_req) begin
            ctrl_rst_n <= 1'b0;
            cnt        <= CNT_W'(RST_PULSE - 1);
            st         <= SQ_RST;
          end else if (irq) begin
            sub <= '0;
            st  <= SQ_SIZE;
          end
        end
        SQ_EMIT: if (rx_ready) begin
          rx_valid <= 1'b0;
          rx_sof   <= 1'b0;
          rx_eof   <= 1'b0;
          sub      <= '0;
          st       <= rx_eof ? SQ_WBP : SQ_DATA;
        end
        default: ;
      endcase
      if (done && is_op) begin
        pend    <= 1'b0;
        word_lo <= rdata;
        if (sub != last_sub) begin
          sub <= sub + 2'd1;
        end else begin
          sub <= '0;
          case (st)
            SQ_SIZE: st <= (rd16 == 16'd0) ? SQ_WAIT : SQ_PTR;
            SQ_PTR:  begin rp <= rd16; st <= SQ_HDR; end
            SQ_HDR:  begin
              flen      <= rd16;
              remaining <= rd16 - 16'd2;
              first     <= 1'b1;
              st        <= (rd16 < 16'd3) ? SQ_WBP : SQ_DATA;
            end
            SQ_DATA: begin
              rx_data   <= rdata;
              rx_valid  <= 1'b1;
              rx_sof    <= first;
              rx_eof    <= (remaining == 16'd1);
              first     <= 1'b0;
              remaining <= remaining - 16'd1;
              st        <= SQ_EMIT;
            end
            SQ_WBP:  st <= SQ_CMD;
            default: st <= SQ_WAIT;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/ipb_rx_reader.sv
module ipb_rx_reader
  import ipb_rx_pkg::*;
#(
  parameter int          STROBE_CYCLES = 2,
  parameter int          RST_PULSE     = 4,
  parameter int          SETTLE_CYCLES = 24000,
  parameter logic [15:0] RX_BASE       = 16'h6000,
  parameter logic [15:0] RX_MASK       = 16'h1FFF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       init_req,
  output logic       ctrl_rst_n,
  input  logic       ctrl_int_n,
  output logic [1:0] bus_addr,
  output logic [7:0] bus_data_o,
  output logic       bus_data_oe,
  input  logic [7:0] bus_data_i,
  output logic       bus_cs_n,
  output logic       bus_rd_n,
  output logic       bus_wr_n,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic       rx_sof,
  output logic       rx_eof
);

  logic [1:0] irq_sync;
  logic       cyc_req, cyc_done;
  bus_op_t    cyc_op;
  logic [7:0] cyc_rdata;

  always_ff @(posedge clk) begin
    if (rst) irq_sync <= '0;
    else     irq_sync <= {irq_sync[0], ~ctrl_int_n};
  end

  ipb_rx_seq #(
    .RST_PULSE(RST_PULSE), .SETTLE_CYCLES(SETTLE_CYCLES),
    .RX_BASE(RX_BASE), .RX_MASK(RX_MASK)
  ) u_seq (
    .clk(clk), .rst(rst), .init_req(init_req), .irq(irq_sync[1]),
    .req(cyc_req), .op(cyc_op), .done(cyc_done), .rdata(cyc_rdata),
    .ctrl_rst_n(ctrl_rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_sof(rx_sof), .rx_eof(rx_eof)
  );

  ipb_bus_cycle #(.STROBE_CYCLES(STROBE_CYCLES)) u_cyc (
    .clk(clk), .rst(rst), .req(cyc_req), .op(cyc_op), .done(cyc_done),
    .rdata(cyc_rdata), .bus_addr(bus_addr), .bus_data_o(bus_data_o),
    .bus_data_oe(bus_data_oe), .bus_data_i(bus_data_i), .bus_cs_n(bus_cs_n),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n)
  );

endmodule

// File: rtl/ipb_rx_reader_chk.sv
module ipb_rx_reader_chk (
  input logic       clk,
  input logic       rst,
  input logic       ctrl_rst_n,
  input logic [7:0] bus_data_o,
  input logic       bus_data_oe,
  input logic       bus_cs_n,
  input logic       bus_rd_n,
  input logic       bus_wr_n,
  input logic [7:0] rx_data,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       rx_sof,
  input logic       rx_eof
);

  AST_CS_SETUP: assert property (@(posedge clk) disable iff (rst)
    ($fell(bus_rd_n) || $fell(bus_wr_n)) |-> $past(!bus_cs_n)); // R4
  AST_CS_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_rd_n) || $rose(bus_wr_n)) |-> !bus_cs_n); // R4
  AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd_n || !bus_wr_n) |-> !bus_cs_n); // R4
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_n |-> bus_wr_n); // R4
  AST_OE_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
    bus_data_oe |-> (!bus_cs_n && bus_rd_n)); // R5
  AST_OE_COVERS_WRITE: assert property (@(posedge clk) disable iff (rst)
    !bus_wr_n |-> bus_data_oe); // R5
  AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
    !bus_wr_n |-> $stable(bus_data_o)); // R5
  AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (rst)
    !ctrl_rst_n |-> bus_cs_n); // R2
  AST_MARK_VALID: assert property (@(posedge clk) disable iff (rst)
    (rx_sof || rx_eof) |-> rx_valid); // R8
  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(rx_sof) && $stable(rx_eof))); // R8

endmodule

bind ipb_rx_reader ipb_rx_reader_chk u_chk (
  .clk(clk), .rst(rst), .ctrl_rst_n(ctrl_rst_n), .bus_data_o(bus_data_o),
  .bus_data_oe(bus_data_oe), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
  .bus_wr_n(bus_wr_n), .rx_data(rx_data), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .rx_sof(rx_sof), .rx_eof(rx_eof)
);

// File: tb/sim_ipb_rx_reader.sv
`timescale 1ns/1ps
module sim_ipb_rx_reader;

  localparam int          RSTP   = 4;
  localparam int          SETTLE = 40;
  localparam logic [15:0] BASE   = 16'h6000;
  localparam logic [15:0] MASK   = 16'h1FFF;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst, init_req, ctrl_rst_n, ctrl_int_n;
  logic [1:0] bus_addr;
  logic [7:0] bus_data_o, bus_data_i;
  logic       bus_data_oe, bus_cs_n, bus_rd_n, bus_wr_n;
  logic [7:0] rx_data;
  logic       rx_valid, rx_ready, rx_sof, rx_eof;

  ipb_rx_reader #(
    .STROBE_CYCLES(2), .RST_PULSE(RSTP), .SETTLE_CYCLES(SETTLE),
    .RX_BASE(BASE), .RX_MASK(MASK)
  ) u0 (
    .clk(clk), .rst(rst), .init_req(init_req), .ctrl_rst_n(ctrl_rst_n),
    .ctrl_int_n(ctrl_int_n), .bus_addr(bus_addr), .bus_data_o(bus_data_o),
    .bus_data_oe(bus_data_oe), .bus_data_i(bus_data_i), .bus_cs_n(bus_cs_n),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_sof(rx_sof), .rx_eof(rx_eof)
  );

  // controller model state
  logic [7:0]  mem [0:65535];
  logic [7:0]  m_mode;
  logic [15:0] m_ar;

  always_comb begin
    case (bus_addr)
      2'd0:    bus_data_i = m_mode;
      2'd1:    bus_data_i = m_ar[15:8];
      2'd2:    bus_data_i = m_ar[7:0];
      default: bus_data_i = mem[m_ar];
    endcase
  end

  int total = 0, bad = 0, cyc = 0;
  int cs_falls = 0, cmd_count = 0, proto_err = 0, rst_low = 0;
  int rst_rise_cyc = -1, first_cs_after = -1, unexpected = 0;
  int wlog[$];
  logic [9:0] expq[$];
  logic seen_wr = 1'b0;
  logic [1:0] first_wr_addr = '0;
  logic [7:0] first_wr_data = '0;
  logic bp = 1'b0, finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_model();
    logic prev_rd = 1'b1, prev_wr = 1'b1, prev_cs = 1'b1, prev_rstn = 1'b1;
    logic [9:0] e;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst) begin
        if (!ctrl_rst_n) rst_low++;
        if (ctrl_rst_n && !prev_rstn) rst_rise_cyc = cyc;
        if (!bus_cs_n && prev_cs) begin
          cs_falls++;
          if (first_cs_after < 0 && rst_rise_cyc >= 0) first_cs_after = cyc;
        end
        if (!bus_wr_n && !bus_data_oe) proto_err++;
        if (bus_data_oe && !bus_rd_n) proto_err++;
        if (bus_wr_n && !prev_wr) begin
          if (bus_cs_n) proto_err++;
          else begin
            if (!seen_wr) begin
              seen_wr = 1'b1; first_wr_addr = bus_addr; first_wr_data = bus_data_o;
            end
            case (bus_addr)
              2'd0: m_mode = bus_data_o;
              2'd1: m_ar[15:8] = bus_data_o;
              2'd2: m_ar[7:0] = bus_data_o;
              default: begin
                mem[m_ar] = bus_data_o;
                wlog.push_back(int'(m_ar));
                if (m_ar == 16'h0401 && bus_data_o == 8'h40) begin
                  cmd_count++;
                  mem[16'h0426] = 8'h00;
                  mem[16'h0427] = 8'h00;
                end
                if (m_mode[1]) m_ar = m_ar + 16'd1;
              end
            endcase
          end
        end
        if (bus_rd_n && !prev_rd && !bus_cs_n && bus_addr == 2'd3 && m_mode[1])
          m_ar = m_ar + 16'd1;
        if (rx_valid && rx_ready) begin
          if (expq.size() == 0) begin
            unexpected++;
            check(1'b0, "R8 unexpected byte", {22'd0, rx_sof, rx_eof, rx_data}, 0);
          end else begin
            e = expq.pop_front();
            check({rx_sof, rx_eof, rx_data} == e, "R8 stream byte/markers",
                  {22'd0, rx_sof, rx_eof, rx_data}, {22'd0, e});
          end
        end
      end
      prev_rd = bus_rd_n; prev_wr = bus_wr_n; prev_cs = bus_cs_n; prev_rstn = ctrl_rst_n;
    end
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic ready_driver();
    forever begin
      @(posedge clk);
      #1 rx_ready = bp ? ((cyc % 3) != 0) : 1'b1;
    end
  endtask

  task automatic wait_cmd(input int c0);
    for (int k = 0; k < 20000 && cmd_count == c0; k++) @(posedge clk);
  endtask

  task automatic run_frame(input logic [15:0] rp, input int n, input bit bp_on, input logic [7:0] seed);
    logic [15:0] a, tot, wp;
    logic [7:0] d;
    int c0, u0c;
    a   = BASE + (rp & MASK);
    tot = 16'(n + 2);
    mem[a]          = tot[15:8];
    mem[a + 16'd1]  = tot[7:0];
    for (int i = 0; i < n; i++) begin
      d = seed + 8'(i * 37);
      mem[a + 16'd2 + 16'(i)] = d;
      expq.push_back({(i == 0), (i == n - 1), d});
    end
    mem[16'h0426] = tot[15:8]; mem[16'h0427] = tot[7:0];
    mem[16'h0428] = rp[15:8];  mem[16'h0429] = rp[7:0];
    c0 = cmd_count; u0c = unexpected;
    wlog.delete();
    bp = bp_on;
    @(posedge clk); #1 ctrl_int_n = 1'b0;
    wait_cmd(c0);
    ctrl_int_n = 1'b1;
    repeat (30) @(posedge clk);
    bp = 1'b0;
    check(expq.size() == 0, "R8 all body bytes delivered", expq.size(), 0);
    check(unexpected == u0c, "R9/R8 no extra byte", unexpected - u0c, 0);
    check(cmd_count == c0 + 1, "R10 one receive command", cmd_count - c0, 1);
    wp = {mem[16'h0428], mem[16'h0429]};
    check(wp == rp + tot, "R10 pointer write-back", int'(wp), int'(rp + tot));
    if (wlog.size() >= 3) begin
      check(wlog[wlog.size()-3] == 32'h0428 && wlog[wlog.size()-2] == 32'h0429 &&
            wlog[wlog.size()-1] == 32'h0401, "R10 write order",
            wlog[wlog.size()-3], 32'h0428);
    end else check(1'b0, "R10 write count", wlog.size(), 3);
    expq.delete();
  endtask

  initial begin
    rst = 1'b1; init_req = 1'b0; ctrl_int_n = 1'b1; rx_ready = 1'b1;
    m_mode = 8'h00; m_ar = 16'h0000;
    for (int i = 0; i < 65536; i++) mem[i] = 8'h00;
    fork
      bus_model();
      ready_driver();
      begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
          check(1'b0, "watchdog expired", 0, 1);
          summary();
        end
      end
    join_none

    repeat (4) @(posedge clk);
    @(negedge clk);
    check(bus_cs_n && bus_rd_n && bus_wr_n && ctrl_rst_n && !bus_data_oe && !rx_valid,
          "R1 reset state", {bus_cs_n, bus_rd_n, bus_wr_n, ctrl_rst_n, bus_data_oe, rx_valid}, 6'b111100);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check(bus_cs_n && ctrl_rst_n && !rx_valid, "R1 first cycle after reset",
          {bus_cs_n, ctrl_rst_n, rx_valid}, 3'b110);

    // R3: interrupt before initialisation is ignored
    @(posedge clk); #1 ctrl_int_n = 1'b0;
    repeat (60) @(posedge clk);
    check(cs_falls == 0, "R3 no bus cycle before init", cs_falls, 0);
    ctrl_int_n = 1'b1;
    repeat (5) @(posedge clk);

    // R2: initialisation
    #1 init_req = 1'b1;
    @(posedge clk); #1 init_req = 1'b0;
    repeat (SETTLE + 60) @(posedge clk);
    check(rst_low == RSTP, "R2 reset pulse width", rst_low, RSTP);
    check(first_cs_after - rst_rise_cyc >= SETTLE && first_cs_after - rst_rise_cyc <= SETTLE + 4,
          "R2 settle wait", first_cs_after - rst_rise_cyc, SETTLE);
    check(seen_wr && first_wr_addr == 2'd0 && first_wr_data == 8'h02, "R2 auto-increment enable",
          {first_wr_addr, first_wr_data}, 10'h002);

    run_frame(16'h0000, 8, 1'b0, 8'h11);   // R7 R8 R10
    run_frame(16'h000A, 5, 1'b1, 8'hA3);   // R8 back-pressure
    run_frame(16'h0030, 1, 1'b0, 8'h5C);   // R8 single byte
    run_frame(16'h0040, 0, 1'b0, 8'h00);   // R9 empty frame
    run_frame(16'h2004, 3, 1'b0, 8'h77);   // R7 pointer masking
    run_frame(16'h0100, 20, 1'b1, 8'h09);  // R8 longer frame

    // R6: zero pending size
    begin
      int c0, u0c;
      mem[16'h0426] = 8'h00; mem[16'h0427] = 8'h00;
      mem[16'h0428] = 8'h01; mem[16'h0429] = 8'h23;
      c0 = cmd_count; u0c = unexpected;
      wlog.delete();
      @(posedge clk); #1 ctrl_int_n = 1'b0;
      repeat (150) @(posedge clk);
      ctrl_int_n = 1'b1;
      repeat (40) @(posedge clk);
      check(cmd_count == c0, "R6 no command on zero size", cmd_count - c0, 0);
      check(wlog.size() == 0, "R6 no data-port write on zero size", wlog.size(), 0);
      check({mem[16'h0428], mem[16'h0429]} == 16'h0123, "R6 pointer untouched",
            int'({mem[16'h0428], mem[16'h0429]}), 32'h0123);
      check(unexpected == u0c, "R6 no output byte", unexpected - u0c, 0);
    end

    check(proto_err == 0, "R4/R5 bus protocol", proto_err, 0);
    summary();
  end

endmodule